// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block caches recent virtual-to-physical page translations. A request presents a 32-bit virtual address, a read/write flag and the identifier of the running process. The upper 20 address bits, the virtual page number, are compared in parallel against every stored entry. The lower 12 bits, the page offset, pass through unchanged. One clock later, registered outputs report one of three outcomes: a hit with the 28-bit physical address, a translation miss, or a write-protection violation.

Each entry holds a valid flag, a page tag, a process tag, a physical page number, a write-permission flag, a reference flag and a dirty flag. A successful access sets the reference flag, and a successful write also sets the dirty flag. The dirty state of the matched entry is returned with each hit.

Entries are loaded through a refill port. A refill takes the lowest empty slot. When no slot is empty, a rotating pointer picks the victim, preferring an entry whose reference flag is clear. A flush input empties the whole buffer in one cycle. Walking page tables and handling faults happen elsewhere; a miss is only reported.

Top module: `xlat_buf`

## Requirements
- R1: A request accepted in cycle t produces rsp_valid in cycle t+1. On a hit, rsp_paddr is the stored 16-bit physical page number in bits 27:12, and bits 27:12 are followed by req_addr[11:0] unchanged in bits 11:0.
- R2: A request whose page number (req_addr[31:12]) and req_pid match no valid entry returns rsp_miss=1, rsp_hit=0 and rsp_paddr=0.
- R3: A hit requires the stored process tag to equal req_pid. The same page number may be held for two processes, and each process gets its own translation.
- R4: A write that hits sets the entry's dirty flag. rsp_dirty is 1 on that response and on every later hit to the entry.
- R5: A write that matches an entry whose write permission is 0 returns rsp_wprot=1, rsp_hit=0 and rsp_paddr=0, and leaves the entry's dirty flag at 0.
- R6: A read that matches an entry without write permission is an ordinary hit.
- R7: After flush is high in one cycle, a lookup in the next cycle misses for every page.
- R8: While the buffer has an empty slot, a refill never evicts a valid entry, so 16 distinct pages can be held together.
- R9: With the buffer full, a refill replaces the first entry with a clear reference flag, searching from the rotating pointer. If every reference flag is set, it replaces the entry at the pointer. After any eviction the pointer moves to the slot after the victim. Refills into empty slots do not move the pointer, and a new entry starts with its reference flag clear.
- R10: When flush and a refill occur in the same cycle, the flush wins and the refilled page is not held.
- R11: After reset, and in any cycle following a cycle with no request, rsp_valid, rsp_hit, rsp_miss, rsp_wprot and rsp_dirty are 0.
- R12: Each valid response asserts exactly one of rsp_hit, rsp_miss and rsp_wprot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_pid | input | 8 | Current process identifier |
| fill_valid | input | 1 | Load one entry this cycle |
| fill_vpn | input | 20 | Virtual page number to load |
| fill_ppn | input | 16 | Physical page number to load |
| fill_pid | input | 8 | Process tag to load |
| fill_wr_ok | input | 1 | Write permission of the loaded entry |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching entry |
| rsp_wprot | output | 1 | Write to a read-only page |
| rsp_dirty | output | 1 | Dirty flag of the hit entry after this access |
| rsp_paddr | output | 28 | Physical address on hit, else 0 |

## Verification
A corrupted tag or process comparison appears at the ports on the very next response, either as a spurious miss or as a wrong physical page. A lost dirty or permission update appears on the following hit to the same page, through rsp_dirty or rsp_wprot. A wrong reference flag or a drifting rotation pointer stays hidden until the buffer is full and a refill occurs. The bench therefore fills all 16 slots, controls which reference flags are set, and then checks which page disappears after each of several successive evictions.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef struct packed {
    logic valid;
    logic ref_b;
    logic dirty;
    logic wr_ok;
  } ent_flags_t;

  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_HIT   = 2'd1,
    RK_MISS  = 2'd2,
    RK_WPROT = 2'd3
  } rsp_kind_e;

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [VPN_W-1:0]   tag_vpn [ENTRIES],
  input  logic [PID_W-1:0]   tag_pid [ENTRIES],
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [PID_W-1:0]   lk_pid,
  output logic               m_any,
  output logic [IDX_W-1:0]   m_idx
);

  logic [ENTRIES-1:0] mvec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign mvec[g] = valid_vec[g] && (tag_vpn[g] == lk_vpn) && (tag_pid[g] == lk_pid);
  end

  assign m_any = |mvec;

  always_comb begin
    m_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (mvec[i]) m_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] ref_vec,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   victim,
  output logic               use_free
);

  logic found;

  always_comb begin
    victim   = rr_ptr;
    use_free = 1'b0;
    found    = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        victim   = IDX_W'(i);
        use_free = 1'b1;
      end
    end
    if (!use_free) begin
      for (int k = 0; k < ENTRIES; k++) begin
        if (!found && !ref_vec[(int'(rr_ptr) + k) % ENTRIES]) begin
          victim = IDX_W'((int'(rr_ptr) + k) % ENTRIES);
          found  = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 28,
  parameter int OFS_W   = 12,
  parameter int PID_W   = 8,
  parameter int ENTRIES = 16,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PPN_W  = PA_W - OFS_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_addr,
  input  logic             req_write,
  input  logic [PID_W-1:0] req_pid,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic             fill_wr_ok,
  input  logic             flush,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_wprot,
  output logic             rsp_dirty,
  output logic [PA_W-1:0]  rsp_paddr
);
  import xlat_pkg::*;

  ent_flags_t       ent_f   [ENTRIES];
  logic [VPN_W-1:0] tag_vpn [ENTRIES];
  logic [PID_W-1:0] tag_pid [ENTRIES];
  logic [PPN_W-1:0] ppn_mem [ENTRIES];

  logic [ENTRIES-1:0] valid_vec, ref_vec;
  logic [IDX_W-1:0]   rr_ptr, victim, m_idx;
  logic               use_free, m_any, do_fill;
  rsp_kind_e          kind;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flags
    assign valid_vec[g] = ent_f[g].valid;
    assign ref_vec[g]   = ent_f[g].ref_b;
  end

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_match (
    .valid_vec (valid_vec),
    .tag_vpn   (tag_vpn),
    .tag_pid   (tag_pid),
    .lk_vpn    (req_addr[VA_W-1:OFS_W]),
    .lk_pid    (req_pid),
    .m_any     (m_any),
    .m_idx     (m_idx)
  );

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid_vec (valid_vec),
    .ref_vec   (ref_vec),
    .rr_ptr    (rr_ptr),
    .victim    (victim),
    .use_free  (use_free)
  );

  assign do_fill = fill_valid && !flush;

  // outcome of the current request
  always_comb begin
    if (!req_valid)                              kind = RK_NONE;
    else if (!m_any)                             kind = RK_MISS;
    else if (req_write && !ent_f[m_idx].wr_ok)   kind = RK_WPROT;
    else                                         kind = RK_HIT;
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_wprot <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= (kind != RK_NONE);
      rsp_hit   <= (kind == RK_HIT);
      rsp_miss  <= (kind == RK_MISS);
      rsp_wprot <= (kind == RK_WPROT);
      rsp_dirty <= (kind == RK_HIT) && (ent_f[m_idx].dirty || req_write);
      rsp_paddr <= (kind == RK_HIT) ? {ppn_mem[m_idx], req_addr[OFS_W-1:0]} : '0;
    end
  end

  // entry flags: flush, then refill, then access update
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) ent_f[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush) begin
          ent_f[i].valid <= 1'b0;
        end else if (fill_valid && victim == IDX_W'(i)) begin
          ent_f[i] <= '{valid: 1'b1, ref_b: 1'b0, dirty: 1'b0, wr_ok: fill_wr_ok};
        end else if (kind == RK_HIT && m_idx == IDX_W'(i)) begin
          ent_f[i].ref_b <= 1'b1;
          if (req_write) ent_f[i].dirty <= 1'b1;
        end
      end
    end
  end

  // tag and page storage, written only by refill
  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_vpn[victim] <= fill_vpn;
      tag_pid[victim] <= fill_pid;
      ppn_mem[victim] <= fill_ppn;
    end
  end

  // rotating replacement pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (do_fill && !use_free) begin
      rr_ptr <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
    end
  end

endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int PA_W  = 28,
  parameter int OFS_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [OFS_W-1:0] req_ofs,
  input logic             req_write,
  input logic             flush,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic             rsp_wprot,
  input logic             rsp_dirty,
  input logic [PA_W-1:0]  rsp_paddr
);

  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_valid));

  a_r1_offset: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_paddr[OFS_W-1:0] == $past(req_ofs));

  a_r2_no_paddr: assert property (@(posedge clk) disable iff (rst)
    (rsp_miss || rsp_wprot) |-> rsp_paddr == '0);

  a_r4_write_dirty: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit && $past(req_write)) |-> rsp_dirty);

  a_r5_wprot_write: assert property (@(posedge clk) disable iff (rst)
    rsp_wprot |-> $past(req_write));

  a_r7_flush_empty: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && req_valid) |=> rsp_miss);

  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_wprot || rsp_dirty));

  a_r12_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_wprot}) == 1);

endmodule

bind xlat_buf xlat_buf_chk #(.PA_W(PA_W), .OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ofs   (req_addr[OFS_W-1:0]),
  .req_write (req_write),
  .flush     (flush),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_wprot (rsp_wprot),
  .rsp_dirty (rsp_dirty),
  .rsp_paddr (rsp_paddr)
);

// File: tb/sim_xlat_buf.sv
module sim_xlat_buf;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_pid = '0;
  logic        fill_valid = 1'b0, fill_wr_ok = 1'b0, flush = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [15:0] fill_ppn = '0;
  logic [7:0]  fill_pid = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_wprot, rsp_dirty;
  logic [27:0] rsp_paddr;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    logic        hit, miss, wprot, dirty;
    logic [27:0] paddr;
    string       req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  xlat_buf u0 (.*);

  task automatic lookup(input logic [31:0] a, input logic w, input logic [7:0] p,
                        input int kind, input logic [15:0] ppn, input logic dty,
                        input string r);
    exp_t e;
    e.hit   = (kind == 0);
    e.miss  = (kind == 1);
    e.wprot = (kind == 2);
    e.dirty = (kind == 0) && dty;
    e.paddr = (kind == 0) ? {ppn, a[11:0]} : 28'h0;
    e.req   = r;
    q.push_back(e);
    req_valid = 1'b1; req_addr = a; req_write = w; req_pid = p;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [15:0] pp, input logic [7:0] p,
                      input logic wok);
    fill_valid = 1'b1; fill_vpn = v; fill_ppn = pp; fill_pid = p; fill_wr_ok = wok;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic idle_check(input string r);
    total++;
    if (rsp_valid || rsp_hit || rsp_miss || rsp_wprot || rsp_dirty) begin
      bad++;
      $display("FAIL %s: idle outputs v=%0b h=%0b m=%0b w=%0b d=%0b, expected all 0",
               r, rsp_valid, rsp_hit, rsp_miss, rsp_wprot, rsp_dirty);
    end
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // monitor: compare each response against the scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R11: unexpected response h=%0b m=%0b w=%0b, expected none",
                 rsp_hit, rsp_miss, rsp_wprot);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_hit !== e.hit || rsp_miss !== e.miss || rsp_wprot !== e.wprot ||
            rsp_dirty !== e.dirty || rsp_paddr !== e.paddr) begin
          bad++;
          $display("FAIL %s: got h=%0b m=%0b w=%0b d=%0b pa=%h, expected h=%0b m=%0b w=%0b d=%0b pa=%h",
                   e.req, rsp_hit, rsp_miss, rsp_wprot, rsp_dirty, rsp_paddr,
                   e.hit, e.miss, e.wprot, e.dirty, e.paddr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R11 reset");
    rst = 1'b0;
    @(negedge clk);
    idle_check("R11 after reset");

    // R2 empty buffer
    lookup(32'h0000_1234, 0, 8'd1, 1, 16'h0, 0, "R2 empty miss");

    // R1 translation with offset passthrough
    fill(20'h00001, 16'h00A5, 8'd1, 1'b1);
    lookup(32'h0000_1ABC, 0, 8'd1, 0, 16'h00A5, 0, "R1 read hit");
    lookup(32'h0000_1FFF, 0, 8'd1, 0, 16'h00A5, 0, "R1 offset max");
    // R4 dirty on write
    lookup(32'h0000_1004, 1, 8'd1, 0, 16'h00A5, 1, "R4 write hit");
    lookup(32'h0000_1008, 0, 8'd1, 0, 16'h00A5, 1, "R4 dirty kept");
    // R3 other process
    lookup(32'h0000_1ABC, 0, 8'd2, 1, 16'h0, 0, "R3 pid mismatch");

    // R5/R6 read-only page
    fill(20'h00002, 16'h00B0, 8'd1, 1'b0);
    lookup(32'h0000_2010, 0, 8'd1, 0, 16'h00B0, 0, "R6 read of read-only");
    lookup(32'h0000_2020, 1, 8'd1, 2, 16'h0, 0, "R5 write protect");
    lookup(32'h0000_2030, 0, 8'd1, 0, 16'h00B0, 0, "R5 dirty untouched");

    // R3 same page, two processes
    fill(20'h00001, 16'h00C0, 8'd2, 1'b1);
    lookup(32'h0000_1111, 0, 8'd2, 0, 16'h00C0, 0, "R3 pid2 translation");
    lookup(32'h0000_1111, 0, 8'd1, 0, 16'h00A5, 1, "R3 pid1 translation");

    // R7 flush
    do_flush();
    lookup(32'h0000_1111, 0, 8'd1, 1, 16'h0, 0, "R7 miss after flush");
    lookup(32'h0000_2010, 0, 8'd1, 1, 16'h0, 0, "R7 miss after flush b");

    // R10 flush beats refill
    fill_valid = 1'b1; fill_vpn = 20'h00005; fill_ppn = 16'h0055; fill_pid = 8'd1;
    fill_wr_ok = 1'b1; flush = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0; flush = 1'b0;
    lookup(32'h0000_5000, 0, 8'd1, 1, 16'h0, 0, "R10 flush wins");

    // R8 fill all 16 slots; page 0x100+k lands in slot k
    do_flush();
    for (int k = 0; k < 16; k++) fill(20'h00100 + 20'(k), 16'h0200 + 16'(k), 8'd3, 1'b1);
    for (int k = 0; k < 15; k++)
      lookup({20'h00100 + 20'(k), 12'h040}, 0, 8'd3, 0, 16'h0200 + 16'(k), 0, "R8 all held");

    // R9 only slot 15 has a clear reference flag
    fill(20'h00200, 16'h0300, 8'd3, 1'b1);
    lookup(32'h0010_F000, 0, 8'd3, 1, 16'h0, 0, "R9 unreferenced slot evicted");
    lookup(32'h0020_0000, 0, 8'd3, 0, 16'h0300, 0, "R9 new page held");
    lookup(32'h0010_0000, 0, 8'd3, 0, 16'h0200, 0, "R9 referenced kept");
    // all referenced now: pointer (slot 0) is the victim
    fill(20'h00201, 16'h0301, 8'd3, 1'b1);
    lookup(32'h0010_0000, 0, 8'd3, 1, 16'h0, 0, "R9 pointer victim");
    lookup(32'h0020_1000, 0, 8'd3, 0, 16'h0301, 0, "R9 second new page");
    lookup(32'h0020_0000, 0, 8'd3, 0, 16'h0300, 0, "R9 earlier page kept");
    lookup(32'h0010_1000, 0, 8'd3, 0, 16'h0201, 0, "R9 slot1 kept");
    // pointer advanced to slot 1
    fill(20'h00202, 16'h0302, 8'd3, 1'b1);
    lookup(32'h0010_1000, 0, 8'd3, 1, 16'h0, 0, "R9 pointer rotated");
    lookup(32'h0010_2000, 0, 8'd3, 0, 16'h0202, 0, "R9 slot2 kept");
    lookup(32'h0020_2000, 0, 8'd3, 0, 16'h0302, 0, "R9 third new page");

    @(negedge clk);
    @(negedge clk);
    idle_check("R11 idle after traffic");
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R1: %0d responses missing, expected 0", q.size());
    end
    done = 1;
    summary();
    $finish;
  end

endmodule